// File: doc/BRIEF.md
# External Interrupt Pin Detector

This block turns four asynchronous external interrupt pins into four interrupt request flags for an 8-bit microcontroller core. Each pin first passes through a chain of flip-flops that brings it into the core clock domain. A machine-cycle strobe then samples the pin, and the block compares each sample with the one taken at the previous strobe. Because only strobe samples count, a pin has to hold its level for at least one full machine cycle to be seen reliably.

Sources 0 and 1 each have a mode bit. When the bit is 1, the source requests on a high-to-low transition. When the bit is 0, it requests while the pin is held low. Source 2 responds only to low-to-high transitions and source 3 only to high-to-low transitions. The rules for clearing a flag depend on the source. An edge-mode flag on source 0 or 1 clears when the core reports that it has taken that vector. A level-mode flag tracks the pin and ignores that report. The flags of sources 2 and 3 clear only by a software write. Software can also force any flag on.

Top module: `ext_irq_detect`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all four flags read 0. The internal samples reset to high, so releasing reset with the pins high raises no flag.
- R2: A pin change reaches the sampling stage after SYNC_STAGES clock edges and has an effect only at a clock edge where `mc_stb` is 1. A low pulse that starts and ends between two strobes is missed, and flags do not change on edges without a strobe except through `sw_clr`, `sw_set` or `svc_ack`.
- R3: With `edge_mode[i]` = 1 (i = 0 or 1), flag i sets at the strobe where the pin is sampled low after it was sampled high at the previous strobe. A low-to-high transition does not set it.
- R4: With `edge_mode[i]` = 0 (i = 0 or 1), flag i sets at every strobe that samples the pin low and clears at every strobe that samples it high. `svc_ack[i]` has no effect on it. After a software clear, the flag sets again at the next strobe if the pin is still low.
- R5: Flag 2 sets only at a strobe where pin 2 is sampled high after a low sample. A high-to-low transition does not set it.
- R6: Flag 3 sets only at a strobe where pin 3 is sampled low after a high sample. A low-to-high transition does not set it.
- R7: With `edge_mode[i]` = 1, a 1 on `svc_ack[i]` clears flag i at that clock edge.
- R8: `svc_ack[2]` and `svc_ack[3]` never clear flags 2 and 3. Only a 1 on the matching `sw_clr` bit clears them.
- R9: If a detected event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: A 1 on `sw_set[i]` sets flag i at that clock edge, whatever the source type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_stb | input | 1 | Machine-cycle sampling strobe, one clock wide |
| pin_i | input | 4 | Asynchronous external interrupt pins, bit i is source i |
| edge_mode | input | 2 | Mode for sources 0 and 1: 1 = falling edge, 0 = low level |
| svc_ack | input | 4 | Core has taken the vector of source i |
| sw_clr | input | 4 | Software write that clears flag i |
| sw_set | input | 4 | Software write that sets flag i |
| irq_flag | output | 4 | Interrupt request flags |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default of 2. Every pin change therefore has to wait through a longer run of strobe-free cycles before the strobe that samples it, and that makes the rule that flags move only on strobes visible over several cycles. The longer chain also lets the bench place a complete low pulse between two strobes and confirm that it is missed. With the sampling latency tied to the parameter, the expected results shift with the chain length, so an off-by-one in the chain or in the sample register shows up as a flag that rises at the wrong time.

// File: rtl/ext_irq_pkg.sv
// Package: shared types for the external interrupt pin detector.
// Assumes four sources; sources below NUM_CFG have a selectable trigger.
package ext_irq_pkg;

    localparam int unsigned NUM_SRC = 4;
    localparam int unsigned NUM_CFG = 2;

    // Trigger rule a detector applies to its sampled pin
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_RISE = 2'd2
    } trig_e;

    // Trigger rule of a source with no mode bit
    function automatic trig_e fixed_trig(input int unsigned idx);
        return (idx == 2) ? TRIG_RISE : TRIG_FALL;
    endfunction

endpackage

// File: rtl/irq_pin_sync.sv
// Module: irq_pin_sync
// Brings one asynchronous pin into the clock domain through STAGES flops.
// Assumes the pin is idle high, so every stage resets to 1.
module irq_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);

    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    // Next chain value: shift the raw pin in at the bottom
    always_comb begin
        chain_d = STAGES'({chain_q, pin_async});
    end

    // Chain register, reset to the inactive high level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign pin_sync = chain_q[STAGES-1];

endmodule

// File: rtl/irq_pin_detect.sv
// Module: irq_pin_detect
// Samples a synchronised pin on the machine-cycle strobe and, given a
// trigger rule, produces a set event and a hardware clear for one flag.
// Assumes mc_stb is one clock wide and that pin_sync is already synchronised.
module irq_pin_detect
    import ext_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mc_stb,
    input  logic  pin_sync,
    input  trig_e trig,
    input  logic  ack,
    input  logic  ack_clr_en,
    output logic  set_ev,
    output logic  hw_clr
);

    logic smp_q;
    logic fall_now;
    logic rise_now;
    logic low_now;
    logic high_now;

    // Sample register: last value seen at a strobe, reset high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_q <= 1'b1;
        end else if (mc_stb) begin
            smp_q <= pin_sync;
        end
    end

    // Strobe-qualified comparisons of the new sample with the previous one
    always_comb begin
        fall_now = mc_stb &  smp_q & ~pin_sync;
        rise_now = mc_stb & ~smp_q &  pin_sync;
        low_now  = mc_stb & ~pin_sync;
        high_now = mc_stb &  pin_sync;
    end

    // Select the set event and the hardware clear by trigger rule
    always_comb begin
        case (trig)
            TRIG_LOW:  set_ev = low_now;
            TRIG_FALL: set_ev = fall_now;
            TRIG_RISE: set_ev = rise_now;
            default:   set_ev = 1'b0;
        endcase
        hw_clr = (trig == TRIG_LOW) ? high_now : (ack & ack_clr_en);
    end

    // R2
    smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_stb |=> $stable(smp_q));

endmodule

// File: rtl/irq_flag_cell.sv
// Module: irq_flag_cell
// One request flag. Set sources (event or software) win over clear
// sources (hardware or software) in the same cycle.
// Assumes all inputs are synchronous to clk.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic hw_clr,
    input  logic sw_set,
    input  logic sw_clr,
    output logic flag_q
);

    // Flag register with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_ev || sw_set) begin
            flag_q <= 1'b1;
        end else if (hw_clr || sw_clr) begin
            flag_q <= 1'b0;
        end
    end

    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev || sw_set) |=> flag_q);

    // R8
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_clr || sw_clr) && !set_ev && !sw_set) |=> !flag_q);

endmodule

// File: rtl/ext_irq_detect.sv
// Module: ext_irq_detect (top)
// Conditions four external interrupt pins into request flags: synchroniser,
// strobe sampler and flag per source. Sources 0 and 1 take a mode bit,
// source 2 is rising only and source 3 is falling only.
// Assumes mc_stb marks machine cycles and that svc_ack pulses for one clock.
module ext_irq_detect
    import ext_irq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mc_stb,
    input  logic [3:0] pin_i,
    input  logic [1:0] edge_mode,
    input  logic [3:0] svc_ack,
    input  logic [3:0] sw_clr,
    input  logic [3:0] sw_set,
    output logic [3:0] irq_flag
);

    logic [NUM_SRC-1:0] pin_s;
    logic [NUM_SRC-1:0] set_ev;
    logic [NUM_SRC-1:0] hw_clr;
    trig_e              trig   [NUM_SRC];
    logic [NUM_SRC-1:0] ack_en;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        if (g < NUM_CFG) begin : g_cfg
            // Configurable source: trigger and ack clearing follow the mode bit
            always_comb begin
                trig[g]   = edge_mode[g] ? TRIG_FALL : TRIG_LOW;
                ack_en[g] = edge_mode[g];
            end
        end else begin : g_fix
            // Fixed-polarity source: ack never clears it
            always_comb begin
                trig[g]   = fixed_trig(g);
                ack_en[g] = 1'b0;
            end
        end

        irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_async (pin_i[g]),
            .pin_sync  (pin_s[g])
        );

        irq_pin_detect u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .mc_stb     (mc_stb),
            .pin_sync   (pin_s[g]),
            .trig       (trig[g]),
            .ack        (svc_ack[g]),
            .ack_clr_en (ack_en[g]),
            .set_ev     (set_ev[g]),
            .hw_clr     (hw_clr[g])
        );

        irq_flag_cell u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_ev (set_ev[g]),
            .hw_clr (hw_clr[g]),
            .sw_set (sw_set[g]),
            .sw_clr (sw_clr[g]),
            .flag_q (irq_flag[g])
        );
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_flag == 4'b0000));

    // R8
    fix2_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag[2] && !sw_clr[2]) |=> irq_flag[2]);

    // R8
    fix3_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag[3] && !sw_clr[3]) |=> irq_flag[3]);

    // R4
    level_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag[1] && !edge_mode[1] && !mc_stb && !sw_clr[1]) |=> irq_flag[1]);

    // R7
    edge_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode[0] && svc_ack[0] && !sw_set[0] && !set_ev[0]) |=> !irq_flag[0]);

endmodule

// File: tb/tb_ext_irq_detect.sv
`timescale 1ns/1ps
module tb_ext_irq_detect;

    localparam int unsigned SYNC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_stb = 1'b0;
    logic [3:0] pin_i = 4'b1111;
    logic [1:0] edge_mode = 2'b11;
    logic [3:0] svc_ack = '0;
    logic [3:0] sw_clr = '0;
    logic [3:0] sw_set = '0;
    logic [3:0] irq_flag;

    int checks = 0;
    int fails = 0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    ext_irq_detect #(.SYNC_STAGES(SYNC)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mc_stb    (mc_stb),
        .pin_i     (pin_i),
        .edge_mode (edge_mode),
        .svc_ack   (svc_ack),
        .sw_clr    (sw_clr),
        .sw_set    (sw_set),
        .irq_flag  (irq_flag)
    );

    // Driver: apply one cycle of stimulus and queue the flags expected after it
    task automatic drive(input logic [3:0] p, input logic s, input logic [3:0] a,
                         input logic [3:0] c, input logic [3:0] st,
                         input logic [3:0] e, input string tag);
        @(negedge clk);
        pin_i = p; mc_stb = s; svc_ack = a; sw_clr = c; sw_set = st;
        @(posedge clk);
        #1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Hold a pin pattern without strobes while it crosses the synchroniser
    task automatic settle(input logic [3:0] p, input logic [3:0] e);
        for (int k = 0; k < SYNC; k++) begin
            drive(p, 1'b0, 4'b0, 4'b0, 4'b0, e, "R2 no strobe, flags hold");
        end
    endtask

    // Monitor: pop expected items and compare with the outputs
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (exp_q.size() > 0) begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (irq_flag !== e) begin
                    fails++;
                    $display("FAIL %s actual=%b expected=%b", t, irq_flag, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog (R1..) actual=timeout expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (irq_flag !== 4'b0000) begin
            fails++;
            $display("FAIL R1 in reset actual=%b expected=0000", irq_flag);
        end
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'b1111, 1'b0, 4'b0, 4'b0, 4'b0, 4'b0000, "R1 after reset");
        drive(4'b1111, 1'b1, 4'b0, 4'b0, 4'b0, 4'b0000, "R1 high pins no flag");

        // Edge mode on source 0
        settle(4'b1110, 4'b0000);
        drive(4'b1110, 1'b1, 4'b0, 4'b0, 4'b0, 4'b0001, "R3 falling sets flag0");
        drive(4'b1110, 1'b0, 4'b0001, 4'b0, 4'b0, 4'b0000, "R7 ack clears flag0");
        settle(4'b1111, 4'b0000);
        drive(4'b1111, 1'b1, 4'b0, 4'b0, 4'b0, 4'b0000, "R3 rising ignored");

        // Fixed sources
        settle(4'b0011, 4'b0000);
        drive(4'b0011, 1'b1, 4'b0, 4'b0, 4'b0, 4'b1000, "R6 pin3 fall / R5 pin2 fall ignored");
        drive(4'b0011, 1'b0, 4'b1111, 4'b0, 4'b0, 4'b1000, "R8 ack ignored by flag3");
        settle(4'b0111, 4'b1000);
        drive(4'b0111, 1'b1, 4'b0, 4'b0, 4'b0, 4'b1100, "R5 pin2 rise sets flag2");
        drive(4'b0111, 1'b0, 4'b1100, 4'b0, 4'b0, 4'b1100, "R8 ack ignored by flags 2,3");
        drive(4'b0111, 1'b0, 4'b0, 4'b1100, 4'b0, 4'b0000, "R8 sw clear");
        settle(4'b1111, 4'b0000);
        drive(4'b1111, 1'b1, 4'b0, 4'b0, 4'b0, 4'b0000, "R6 pin3 rise ignored");

        // Event beats software clear
        settle(4'b0111, 4'b0000);
        drive(4'b0111, 1'b1, 4'b0, 4'b1000, 4'b0, 4'b1000, "R9 event wins over clear");
        drive(4'b0111, 1'b0, 4'b0, 4'b1000, 4'b0, 4'b0000, "R8 sw clear flag3");

        // Level mode on source 1
        edge_mode = 2'b01;
        settle(4'b0101, 4'b0000);
        drive(4'b0101, 1'b1, 4'b0, 4'b0, 4'b0, 4'b0010, "R4 low level sets flag1");
        drive(4'b0101, 1'b0, 4'b0010, 4'b0, 4'b0, 4'b0010, "R4 ack ignored in level");
        drive(4'b0101, 1'b0, 4'b0, 4'b0010, 4'b0, 4'b0000, "R4 sw clear");
        drive(4'b0101, 1'b1, 4'b0, 4'b0, 4'b0, 4'b0010, "R4 re-request while low");
        settle(4'b0111, 4'b0010);
        drive(4'b0111, 1'b1, 4'b0, 4'b0, 4'b0, 4'b0000, "R4 high sample clears");

        // Software set
        drive(4'b0111, 1'b0, 4'b0, 4'b0, 4'b0101, 4'b0101, "R10 sw set");
        drive(4'b0111, 1'b0, 4'b0, 4'b0101, 4'b0, 4'b0000, "R10 clear after set");

        // Short pulse between strobes on edge-mode source 0
        settle(4'b0110, 4'b0000);
        settle(4'b0111, 4'b0000);
        drive(4'b0111, 1'b1, 4'b0, 4'b0, 4'b0, 4'b0000, "R2 pulse between strobes missed");

        drive(4'b0111, 1'b0, 4'b0, 4'b0, 4'b0, 4'b0000, "R2 idle");
        repeat (2) @(posedge clk);
        #3;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule